// File: doc/BRIEF.md
# Epoch-Marked Hit Stream Formatter

This block sits behind a self-triggered front-end. It takes detected hits (a channel address and an amplitude) and writes them out as a stream of records that never carries a full absolute time. Time advances one step on every cycle in which the `tick` input is high. Time is split into fixed epochs of `EPOCH_LEN` ticks, and each epoch has a wrapping epoch number. Each hit leaves as a hit record that carries only its offset inside the current epoch. A separate marker record announces each new epoch number. A consumer rebuilds the absolute time of a hit from the number in the last marker it saw and the hit's offset.

Hits enter through a valid/ready port and wait in a small FIFO. Each FIFO entry is tagged with the epoch in which the hit was taken. One registered output stage sends markers and hits in time order over a valid/ready port. Every epoch gets exactly one marker, whether or not it holds any hits. Markers are not dropped when the output stalls. If two or more markers fall behind, a sticky flag reports it.

Top module: `epoch_hit_formatter`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and `lag_flag` are 0 and `hit_ready` is 1. The first record after reset is a marker for epoch 0.
- R2: `out_kind` is 1 for an epoch marker and 0 for a hit. A marker carries its number in `out_epoch`, with `out_offset`, `out_chan` and `out_amp` at 0. A hit carries `out_offset`, `out_chan` and `out_amp`, with `out_epoch` at 0.
- R3: An epoch lasts `EPOCH_LEN` tick cycles. Exactly one marker goes out per epoch, including epochs with no hits. Marker numbers rise by one modulo 2^`EPOCH_W`, so epoch 0 follows the highest epoch number.
- R4: A hit's offset is the number of ticks counted since its epoch began, as held in the cycle the hit is accepted. The marker sent just before the hit has that hit's epoch number.
- R5: A hit accepted in the first cycle of a new epoch has offset 0 and goes out after that epoch's marker. A hit accepted in the last cycle of an epoch has offset `EPOCH_LEN`-1 and goes out before the next marker.
- R6: Hits go out in the order they were accepted, each exactly once, so record times never decrease. When a marker is due and the oldest buffered hit belongs to a later epoch, the marker is sent first.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output record stays valid and unchanged.
- R8: With the output stalled, the block buffers `FIFO_DEPTH`+1 hits (the FIFO plus the output register) and then holds `hit_ready` at 0. No hit is dropped.
- R9: `lag_flag` sets once two or more markers are outstanding, which happens when a stall spans at least two epoch boundaries. It stays set until reset. A stall that spans only one boundary does not set it, and no marker is lost in either case.
- R10: While `tick` is 0, time does not advance, so hits accepted in that span share one offset and one epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time advances one step at a clock edge when high |
| hit_valid | input | 1 | A hit is offered |
| hit_ready | output | 1 | A hit can be accepted this cycle |
| hit_chan | input | CHAN_W | Channel address of the hit |
| hit_amp | input | AMP_W | Amplitude of the hit |
| out_valid | output | 1 | Output record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 1 | 1 = epoch marker, 0 = hit |
| out_epoch | output | EPOCH_W | Epoch number (markers only) |
| out_offset | output | OFS_W | Offset inside the epoch (hits only) |
| out_chan | output | CHAN_W | Channel address (hits only) |
| out_amp | output | AMP_W | Amplitude (hits only) |
| lag_flag | output | 1 | Sticky: markers fell behind by two or more |

## Verification
An epoch rollover and the acceptance of a hit can happen in the same cycle. Around that rollover, buffered hits from the closing epoch and the new epoch's marker compete for the single output slot. The bench provokes this by offering one hit in the last cycle of an epoch and a second hit in the very next cycle. It then judges the order and offsets of the records that come out: the old hit with offset `EPOCH_LEN`-1, then the marker, then the new hit with offset 0. A stalled output spanning one and then several boundaries sets up the same competition between queued markers and buffered hits. It also exercises the lag flag.

// File: rtl/efmt_pkg.sv
package efmt_pkg;
  typedef enum logic {
    REC_HIT  = 1'b0,
    REC_MARK = 1'b1
  } rec_kind_e;
endpackage

// File: rtl/efmt_timebase.sv
module efmt_timebase #(
  parameter int EPOCH_LEN = 1000,
  parameter int OFS_W     = 10,
  parameter int EPOCH_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [OFS_W-1:0]   ofs,
  output logic [EPOCH_W-1:0] epoch
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(EPOCH_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs   <= '0;
      epoch <= '0;
    end else if (tick) begin
      if (ofs == LAST) begin
        ofs   <= '0;
        epoch <= epoch + 1'b1;
      end else begin
        ofs <= ofs + 1'b1;
      end
    end
  end

  // R3
  rollover_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && ofs == LAST) |=> (ofs == '0 && epoch == EPOCH_W'($past(epoch) + 1'b1)));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(ofs) && $stable(epoch)));
endmodule

// File: rtl/efmt_hit_fifo.sv
module efmt_hit_fifo #(
  parameter int WIDTH = 46,
  parameter int DEPTH = 16   // power of two
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/efmt_out_arb.sv
module efmt_out_arb
  import efmt_pkg::*;
#(
  parameter int EPOCH_W = 16,
  parameter int OFS_W   = 10,
  parameter int CHAN_W  = 8,
  parameter int AMP_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EPOCH_W-1:0] cur_epoch,
  input  logic               head_valid,
  input  logic [EPOCH_W-1:0] head_epoch,
  input  logic [OFS_W-1:0]   head_ofs,
  input  logic [CHAN_W-1:0]  head_chan,
  input  logic [AMP_W-1:0]   head_amp,
  output logic               pop,
  input  logic               out_ready,
  output logic               out_valid,
  output rec_kind_e          out_kind,
  output logic [EPOCH_W-1:0] out_epoch,
  output logic [OFS_W-1:0]   out_offset,
  output logic [CHAN_W-1:0]  out_chan,
  output logic [AMP_W-1:0]   out_amp,
  output logic               lag_flag
);
  // epoch number of the last marker placed in the output register
  logic [EPOCH_W-1:0] sent_ep;
  logic [EPOCH_W-1:0] backlog;
  logic slot_free, head_now, mark_due, take_hit, take_mark;

  always_comb begin
    slot_free = !out_valid || out_ready;
    head_now  = head_valid && (head_epoch == sent_ep);
    mark_due  = (sent_ep != cur_epoch);
    take_hit  = slot_free && head_now;
    take_mark = slot_free && !head_now && mark_due;
    backlog   = cur_epoch - sent_ep;
  end

  assign pop = take_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_kind   <= REC_HIT;
      out_epoch  <= '0;
      out_offset <= '0;
      out_chan   <= '0;
      out_amp    <= '0;
      sent_ep    <= '1;
    end else if (take_hit) begin
      out_valid  <= 1'b1;
      out_kind   <= REC_HIT;
      out_epoch  <= '0;
      out_offset <= head_ofs;
      out_chan   <= head_chan;
      out_amp    <= head_amp;
    end else if (take_mark) begin
      out_valid  <= 1'b1;
      out_kind   <= REC_MARK;
      out_epoch  <= sent_ep + 1'b1;
      out_offset <= '0;
      out_chan   <= '0;
      out_amp    <= '0;
      sent_ep    <= sent_ep + 1'b1;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          lag_flag <= 1'b0;
    else if (backlog > EPOCH_W'(1))   lag_flag <= 1'b1;
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_kind, out_epoch, out_offset, out_chan, out_amp})));

  // R9
  lag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lag_flag |=> lag_flag);
endmodule

// File: rtl/epoch_hit_formatter.sv
module epoch_hit_formatter
  import efmt_pkg::*;
#(
  parameter int EPOCH_LEN  = 1000,
  parameter int OFS_W      = $clog2(EPOCH_LEN),
  parameter int EPOCH_W    = 16,
  parameter int CHAN_W     = 8,
  parameter int AMP_W      = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               hit_valid,
  output logic               hit_ready,
  input  logic [CHAN_W-1:0]  hit_chan,
  input  logic [AMP_W-1:0]   hit_amp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_kind,
  output logic [EPOCH_W-1:0] out_epoch,
  output logic [OFS_W-1:0]   out_offset,
  output logic [CHAN_W-1:0]  out_chan,
  output logic [AMP_W-1:0]   out_amp,
  output logic               lag_flag
);
  localparam int ENTRY_W = EPOCH_W + OFS_W + CHAN_W + AMP_W;

  logic [OFS_W-1:0]   now_ofs;
  logic [EPOCH_W-1:0] now_epoch;
  logic               fifo_empty, fifo_full, wr_en, rd_en;
  logic [ENTRY_W-1:0] wr_entry, head_entry;
  rec_kind_e          kind;

  efmt_timebase #(
    .EPOCH_LEN(EPOCH_LEN), .OFS_W(OFS_W), .EPOCH_W(EPOCH_W)
  ) u_timebase (
    .clk(clk), .rst(rst), .tick(tick), .ofs(now_ofs), .epoch(now_epoch)
  );

  assign hit_ready = !fifo_full;
  assign wr_en     = hit_valid && hit_ready;
  assign wr_entry  = {now_epoch, now_ofs, hit_chan, hit_amp};

  efmt_hit_fifo #(
    .WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_entry),
    .rd_en(rd_en), .rd_data(head_entry), .empty(fifo_empty), .full(fifo_full)
  );

  efmt_out_arb #(
    .EPOCH_W(EPOCH_W), .OFS_W(OFS_W), .CHAN_W(CHAN_W), .AMP_W(AMP_W)
  ) u_arb (
    .clk(clk), .rst(rst), .cur_epoch(now_epoch),
    .head_valid(!fifo_empty),
    .head_epoch(head_entry[ENTRY_W-1 -: EPOCH_W]),
    .head_ofs(head_entry[CHAN_W+AMP_W +: OFS_W]),
    .head_chan(head_entry[AMP_W +: CHAN_W]),
    .head_amp(head_entry[AMP_W-1:0]),
    .pop(rd_en),
    .out_ready(out_ready), .out_valid(out_valid), .out_kind(kind),
    .out_epoch(out_epoch), .out_offset(out_offset), .out_chan(out_chan),
    .out_amp(out_amp), .lag_flag(lag_flag)
  );

  assign out_kind = kind;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !lag_flag && hit_ready));
endmodule

// File: tb/test_epoch_hit_formatter.sv
module test_epoch_hit_formatter;
  localparam int EL = 20;
  localparam int OW = 5;
  localparam int EW = 4;
  localparam int CW = 8;
  localparam int AW = 12;
  localparam int DEPTH = 8;
  localparam int NEP = 1 << EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic hit_valid = 1'b0;
  logic hit_ready;
  logic [CW-1:0] hit_chan = '0;
  logic [AW-1:0] hit_amp = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_kind;
  logic [EW-1:0] out_epoch;
  logic [OW-1:0] out_offset;
  logic [CW-1:0] out_chan;
  logic [AW-1:0] out_amp;
  logic lag_flag;

  epoch_hit_formatter #(
    .EPOCH_LEN(EL), .OFS_W(OW), .EPOCH_W(EW), .CHAN_W(CW), .AMP_W(AW),
    .FIFO_DEPTH(DEPTH)
  ) i_epoch_hit_formatter (
    .clk(clk), .rst(rst), .tick(tick), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_chan(hit_chan), .hit_amp(hit_amp),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_epoch(out_epoch), .out_offset(out_offset), .out_chan(out_chan),
    .out_amp(out_amp), .lag_flag(lag_flag)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [EW-1:0] ep;
    logic [OW-1:0] ofs;
    logic [CW-1:0] ch;
    logic [AW-1:0] amp;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errs = 0;
  int   tick_total = 0;
  int   last_mark = NEP - 1;
  int   mark_seen = 0;
  bit   expect_first = 1'b1;
  bit   wrap_seen = 1'b0;
  bit   log_en = 1'b0;
  logic lg_kind[$];
  int   lg_ofs[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // time reference: ticks counted at edges outside reset
  always @(posedge clk) begin
    if (rst) tick_total <= 0;
    else if (tick) tick_total <= tick_total + 1;
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (log_en) begin
        lg_kind.push_back(out_kind);
        lg_ofs.push_back(int'(out_offset));
      end
      if (expect_first) begin
        chk(out_kind == 1'b1 && out_epoch == '0, "R1 first record is marker 0",
            {out_kind, out_epoch}, {1'b1, {EW{1'b0}}});
        expect_first = 1'b0;
      end
      if (out_kind) begin
        chk(int'(out_epoch) == (last_mark + 1) % NEP, "R3 marker sequence",
            out_epoch, (last_mark + 1) % NEP);
        chk(out_offset == '0 && out_chan == '0 && out_amp == '0, "R2 marker fields zero",
            {out_offset, out_chan, out_amp}, 0);
        if (last_mark == NEP - 1 && out_epoch == '0) wrap_seen = 1'b1;
        last_mark = int'(out_epoch);
        mark_seen++;
      end else begin
        chk(exp_q.size() > 0, "R6 no unexpected hit", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_epoch == '0, "R2 hit epoch field zero", out_epoch, 0);
          chk(out_chan == e.ch && out_amp == e.amp, "R6 hit order/content",
              {out_chan, out_amp}, {e.ch, e.amp});
          chk(out_offset == e.ofs, "R4 hit offset", out_offset, e.ofs);
          chk(int'(e.ep) == last_mark, "R4 hit follows its epoch marker", last_mark, e.ep);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [CW-1:0] c, input logic [AW-1:0] a);
    exp_t e;
    hit_valid = 1'b1;
    hit_chan  = c;
    hit_amp   = a;
    while (!hit_ready) step();
    e.ep  = EW'((tick_total / EL) % NEP);
    e.ofs = OW'(tick_total % EL);
    e.ch  = c;
    e.amp = a;
    exp_q.push_back(e);
    step();
    hit_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int i = 0; i < 400 && (exp_q.size() > 0 || out_valid); i++) step();
    repeat (3) step();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    hit_valid = 1'b0;
    out_ready = 1'b1;
    tick = 1'b1;
    repeat (2) step();
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(lag_flag == 1'b0, "R1 lag_flag in reset", lag_flag, 0);
    chk(hit_ready == 1'b1, "R1 hit_ready in reset", hit_ready, 1);
    exp_q.delete();
    last_mark = NEP - 1;
    expect_first = 1'b1;
    rst = 1'b0;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk(lag_flag == 1'b0, "R1 lag_flag after reset", lag_flag, 0);
    repeat (4) step();
    chk(expect_first == 1'b0, "R1 marker 0 delivered", expect_first, 0);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 30; i++) begin
      push(CW'(i * 37 + 5), AW'(i * 291 + 17));
      repeat (i % 4) step();
    end
    drain();
    chk(exp_q.size() == 0, "R6 all stream hits delivered", exp_q.size(), 0);
  endtask

  task automatic t_empty_epochs();
    int m0;
    while (tick_total % EL != 1) step();
    m0 = mark_seen;
    repeat (3 * EL) step();
    chk(mark_seen - m0 == 3, "R3 one marker per hit-free epoch", mark_seen - m0, 3);
  endtask

  task automatic t_boundary();
    while (tick_total % EL != 2) step();
    log_en = 1'b1;
    lg_kind.delete();
    lg_ofs.delete();
    while (tick_total % EL != EL - 1) step();
    push(8'hA1, 12'h111);
    push(8'hB2, 12'h222);
    repeat (8) step();
    log_en = 1'b0;
    chk(lg_kind.size() == 3, "R5 record count at rollover", lg_kind.size(), 3);
    if (lg_kind.size() == 3) begin
      chk(lg_kind[0] == 1'b0 && lg_ofs[0] == EL - 1, "R5 last-cycle hit before marker",
          lg_ofs[0], EL - 1);
      chk(lg_kind[1] == 1'b1, "R5 marker between hits", lg_kind[1], 1);
      chk(lg_kind[2] == 1'b0 && lg_ofs[2] == 0, "R5 first-cycle hit offset 0",
          lg_ofs[2], 0);
    end
    drain();
  endtask

  task automatic t_freeze();
    log_en = 1'b1;
    lg_kind.delete();
    lg_ofs.delete();
    tick = 1'b0;
    step();
    push(8'h10, 12'h001);
    push(8'h11, 12'h002);
    push(8'h12, 12'h003);
    repeat (6) step();
    log_en = 1'b0;
    chk(lg_ofs.size() == 3, "R10 frozen hits delivered", lg_ofs.size(), 3);
    if (lg_ofs.size() == 3)
      chk(lg_ofs[0] == lg_ofs[1] && lg_ofs[1] == lg_ofs[2], "R10 shared offset",
          lg_ofs[2], lg_ofs[0]);
    tick = 1'b1;
    drain();
  endtask

  task automatic t_capacity();
    int acc = 0;
    drain();
    tick = 1'b0;
    out_ready = 1'b0;
    step();
    for (int i = 0; i < DEPTH + 6; i++) begin
      if (hit_ready) begin
        exp_t e;
        hit_valid = 1'b1;
        hit_chan  = CW'(100 + i);
        hit_amp   = AW'(500 + i * 3);
        e.ep  = EW'((tick_total / EL) % NEP);
        e.ofs = OW'(tick_total % EL);
        e.ch  = hit_chan;
        e.amp = hit_amp;
        exp_q.push_back(e);
        acc++;
      end else begin
        hit_valid = 1'b0;
      end
      step();
    end
    hit_valid = 1'b0;
    chk(acc == DEPTH + 1, "R8 buffered hit count", acc, DEPTH + 1);
    chk(hit_ready == 1'b0, "R8 hit_ready low when full", hit_ready, 0);
    tick = 1'b1;
    drain();
    chk(exp_q.size() == 0, "R8 no hit dropped", exp_q.size(), 0);
  endtask

  task automatic t_stall();
    logic [EW+OW+CW+AW:0] snap;
    int waited = 0;
    drain();
    out_ready = 1'b0;
    while (!out_valid && waited < 3 * EL) begin
      step();
      waited++;
    end
    snap = {out_kind, out_epoch, out_offset, out_chan, out_amp};
    repeat (EL - 4) step();
    chk(out_valid == 1'b1, "R7 valid held under stall", out_valid, 1);
    chk({out_kind, out_epoch, out_offset, out_chan, out_amp} == snap, "R7 record held",
        {out_kind, out_epoch, out_offset, out_chan, out_amp}, snap);
    chk(lag_flag == 1'b0, "R9 single boundary no lag", lag_flag, 0);
    repeat (2 * EL + 4) step();
    chk(lag_flag == 1'b1, "R9 lag set after long stall", lag_flag, 1);
    drain();
    repeat (2 * EL) step();
    chk(lag_flag == 1'b1, "R9 lag stays set", lag_flag, 1);
  endtask

  task automatic t_wrap();
    wrap_seen = 1'b0;
    push(8'h55, 12'h0AA);
    repeat ((NEP + 1) * EL) step();
    push(8'h66, 12'h0BB);
    drain();
    chk(wrap_seen == 1'b1, "R3 epoch number wraps to 0", wrap_seen, 1);
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream();
    t_empty_epochs();
    t_boundary();
    t_freeze();
    t_capacity();
    t_stall();
    do_reset();
    t_wrap();
    chk(exp_q.size() == 0, "R6 expected queue empty at end", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule